// File: doc/BRIEF.md
# Multi-channel UART interrupt aggregator

This block collects the interrupt requests of eight UART channels into one 32-bit status word that a host can take in a single dword read. The low byte has one summary bit per channel. Above it, each channel has a 3-bit field that names its highest-priority pending source. A single registered, active-high interrupt line tells the host that at least one channel needs service.

Each channel drives five request lines: line status, receive data, receive timeout, transmit empty and modem status. A pulse on any of these lines is enough, because the block latches every request until that channel is acknowledged. Three device-wide events are reported only in channel 0's field: a timer request, a multipurpose I/O request and a wake-up. The wake-up is taken only when all eight channels were asleep at the moment the wake event arrives. The bus logic raises a channel's acknowledge strobe when the host reads that channel's own source register. The strobe clears every latched source of that channel. A request line that is still high during the acknowledge cycle is latched again, so its code shows in the next cycle.

Top module: `uart_irq_agg`

## Requirements
- R1: While reset is held, and in the first cycle after it, `intStatus` is all zeros and `hostIrq` is 0.
- R2: Bit N of `intStatus` (N = 0..7, bit 0 for channel 0) is 1 exactly when the 3-bit field of channel N is nonzero.
- R3: Channel N's source code sits at `intStatus[8+3N+2 : 8+3N]`, so channel 0 is at [10:8] and channel 7 is at [31:29]. Requests on one channel change no other channel's field.
- R4: The field holds the code of the highest-priority latched source. The codes, from highest priority to lowest, are: 3'b001 line status, 3'b010 receive data, 3'b011 receive timeout, 3'b100 transmit empty, 3'b101 modem status, 3'b110 timer or multipurpose I/O, 3'b111 wake-up. 3'b000 means nothing is pending. A request seen at a clock edge shows in the field right after that edge.
- R5: A latched request stays pending after its request line falls. It is cleared only when `srcAck[N]` is high at a clock edge, and that acknowledge clears all of channel N's latched sources.
- R6: If a request line of channel N is still high in the cycle where `srcAck[N]` is high, that source stays pending. Its code replaces the old one right after that edge.
- R7: `timerReq` and `gpioReq` set only channel 0's code 3'b110. Channels 1 to 7 never show 3'b110 or 3'b111.
- R8: A `wakeEvent` pulse while all eight `chanAsleep` bits are 1 latches code 3'b111 in channel 0. The code stays until `srcAck[0]`.
- R9: A `wakeEvent` while any `chanAsleep` bit is 0 has no effect on `intStatus`.
- R10: `hostIrq` equals the OR of the summary bits as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStatReq | input | 8 | Line-status request, one bit per channel |
| rxDataReq | input | 8 | Receive-data request, one bit per channel |
| rxTimeoutReq | input | 8 | Receive-timeout request, one bit per channel |
| txEmptyReq | input | 8 | Transmit-empty request, one bit per channel |
| modemReq | input | 8 | Modem-status request, one bit per channel |
| timerReq | input | 1 | Device timer request, reported in channel 0 |
| gpioReq | input | 1 | Multipurpose I/O request, reported in channel 0 |
| chanAsleep | input | 8 | Sleep state of each channel |
| wakeEvent | input | 1 | Device wake-up pulse |
| srcAck | input | 8 | Per-channel acknowledge, high when the host reads that channel's source register |
| intStatus | output | 32 | Global status word: summary byte plus eight 3-bit codes |
| hostIrq | output | 1 | Registered interrupt to the host |

## Verification
Two events can fall in the same cycle: a channel's acknowledge and a new or still-held request on that same channel. The bench provokes this on purpose. It holds transmit-empty through an acknowledge of a channel that also had receive and modem requests latched. It also raises a line-status request on an idle channel in the exact cycle of its acknowledge, and in a third case it raises a wake event together with the acknowledge of channel 0. A behavioural model compares every cycle and decides which event wins: a request that is present survives, and everything else is cleared. Directed checks then read the affected field one cycle later and again after a plain acknowledge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int CH_COUNT   = 8;
  localparam int SRC_COUNT  = 7;
  localparam int CODE_BITS  = 3;

  // source slot order in the pending vector = priority order (slot 0 highest)
  typedef enum logic [CODE_BITS-1:0] {
    CODE_NONE  = 3'b000,
    CODE_LINE  = 3'b001,
    CODE_RXD   = 3'b010,
    CODE_RXTO  = 3'b011,
    CODE_TXE   = 3'b100,
    CODE_MODEM = 3'b101,
    CODE_DEV   = 3'b110,
    CODE_WAKE  = 3'b111
  } irq_code_e;

  typedef struct packed {
    logic devSet;
    logic wakeSet;
    logic wakeClr;
  } ctrl_strobe_t;

  function automatic logic [CODE_BITS-1:0] prioCode(input logic [SRC_COUNT-1:0] pend);
    logic [CODE_BITS-1:0] c;
    c = '0;
    for (int s = SRC_COUNT - 1; s >= 0; s--) begin
      if (pend[s]) c = CODE_BITS'(s + 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int NUM_CH = CH_COUNT
) (
  input  logic              timerReq,
  input  logic              gpioReq,
  input  logic [NUM_CH-1:0] chanAsleep,
  input  logic              wakeEvent,
  input  logic [NUM_CH-1:0] srcAck,
  output ctrl_strobe_t      strb,
  output logic [NUM_CH-1:0] chanClr
);
  always_comb begin
    strb.devSet  = timerReq | gpioReq;
    // R8 R9: wake only counts when every channel is asleep
    strb.wakeSet = wakeEvent & (&chanAsleep);
    strb.wakeClr = srcAck[0];
    chanClr      = srcAck;
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int NUM_CH  = CH_COUNT,
  parameter int NUM_SRC = SRC_COUNT,
  parameter int CODE_W  = CODE_BITS,
  localparam int STATUS_W = NUM_CH + NUM_CH * CODE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   lineStatReq,
  input  logic [NUM_CH-1:0]   rxDataReq,
  input  logic [NUM_CH-1:0]   rxTimeoutReq,
  input  logic [NUM_CH-1:0]   txEmptyReq,
  input  logic [NUM_CH-1:0]   modemReq,
  input  logic                wakeEvent,
  input  logic [NUM_CH-1:0]   chanAsleep,
  input  ctrl_strobe_t        strb,
  input  logic [NUM_CH-1:0]   chanClr,
  output logic [STATUS_W-1:0] intStatus,
  output logic                hostIrq
);
  logic [NUM_SRC-1:0] pend   [NUM_CH];
  logic [NUM_SRC-1:0] setVec [NUM_CH];
  logic [NUM_SRC-1:0] clrVec [NUM_CH];
  logic [CODE_W-1:0]  code   [NUM_CH];
  logic [NUM_CH-1:0]  summary;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    if (n == 0) begin : g_dev
      assign setVec[n] = {strb.wakeSet, strb.devSet, modemReq[n], txEmptyReq[n],
                          rxTimeoutReq[n], rxDataReq[n], lineStatReq[n]};
      assign clrVec[n] = {strb.wakeClr, {(NUM_SRC-1){chanClr[n]}}};
    end else begin : g_plain
      assign setVec[n] = {2'b00, modemReq[n], txEmptyReq[n],
                          rxTimeoutReq[n], rxDataReq[n], lineStatReq[n]};
      assign clrVec[n] = {NUM_SRC{chanClr[n]}};
    end

    // R5 R6: acknowledge clears, a request present in the same cycle wins
    always_ff @(posedge clk) begin
      if (!rstN) pend[n] <= '0;
      else       pend[n] <= (pend[n] & ~clrVec[n]) | setVec[n];
    end

    assign code[n]    = prioCode(pend[n]);
    assign summary[n] = |pend[n];
    assign intStatus[n] = summary[n];
    assign intStatus[NUM_CH + CODE_W*n +: CODE_W] = code[n];

    // R4
    line_top_chk: assert property (@(posedge clk) disable iff (!rstN)
      lineStatReq[n] |=> code[n] == CODE_W'(1));

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chanClr[n] && setVec[n] == '0) |=> code[n] == '0);

    // R2
    summary_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      intStatus[n] == (intStatus[NUM_CH + CODE_W*n +: CODE_W] != '0));
  end

  // R9
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(code[0] == CODE_W'(7)) |-> $past(wakeEvent && (&chanAsleep)));

  always_ff @(posedge clk) begin
    if (!rstN) hostIrq <= 1'b0;
    else       hostIrq <= |summary;
  end

  // R10
  irq_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> $past(intStatus[NUM_CH-1:0] != '0));
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
  import uart_irq_pkg::*;
#(
  parameter int NUM_CH  = CH_COUNT,
  parameter int NUM_SRC = SRC_COUNT,
  parameter int CODE_W  = CODE_BITS,
  localparam int STATUS_W = NUM_CH + NUM_CH * CODE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   lineStatReq,
  input  logic [NUM_CH-1:0]   rxDataReq,
  input  logic [NUM_CH-1:0]   rxTimeoutReq,
  input  logic [NUM_CH-1:0]   txEmptyReq,
  input  logic [NUM_CH-1:0]   modemReq,
  input  logic                timerReq,
  input  logic                gpioReq,
  input  logic [NUM_CH-1:0]   chanAsleep,
  input  logic                wakeEvent,
  input  logic [NUM_CH-1:0]   srcAck,
  output logic [STATUS_W-1:0] intStatus,
  output logic                hostIrq
);
  ctrl_strobe_t      strb;
  logic [NUM_CH-1:0] chanClr;

  uart_irq_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .timerReq  (timerReq),
    .gpioReq   (gpioReq),
    .chanAsleep(chanAsleep),
    .wakeEvent (wakeEvent),
    .srcAck    (srcAck),
    .strb      (strb),
    .chanClr   (chanClr)
  );

  uart_irq_dp #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .lineStatReq (lineStatReq),
    .rxDataReq   (rxDataReq),
    .rxTimeoutReq(rxTimeoutReq),
    .txEmptyReq  (txEmptyReq),
    .modemReq    (modemReq),
    .wakeEvent   (wakeEvent),
    .chanAsleep  (chanAsleep),
    .strb        (strb),
    .chanClr     (chanClr),
    .intStatus   (intStatus),
    .hostIrq     (hostIrq)
  );
endmodule

// File: tb/uart_irq_agg_bench.sv
`timescale 1ns/1ps
module uart_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  lineStatReq = '0, rxDataReq = '0, rxTimeoutReq = '0;
  logic [7:0]  txEmptyReq = '0, modemReq = '0, chanAsleep = '0, srcAck = '0;
  logic        timerReq = 1'b0, gpioReq = 1'b0, wakeEvent = 1'b0;
  logic [31:0] intStatus;
  logic        hostIrq;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_agg u_uart_irq_agg (
    .clk(clk), .rstN(rstN),
    .lineStatReq(lineStatReq), .rxDataReq(rxDataReq), .rxTimeoutReq(rxTimeoutReq),
    .txEmptyReq(txEmptyReq), .modemReq(modemReq),
    .timerReq(timerReq), .gpioReq(gpioReq),
    .chanAsleep(chanAsleep), .wakeEvent(wakeEvent), .srcAck(srcAck),
    .intStatus(intStatus), .hostIrq(hostIrq)
  );

  // behavioural reference: pending[ch][slot], slot k has code k+1
  bit          pending [8][7];
  logic [31:0] expWord = '0;
  bit          expIrq = 0;

  function automatic logic [31:0] modelWord();
    logic [31:0] w = '0;
    for (int ch = 0; ch < 8; ch++) begin
      int c = 0;
      for (int s = 6; s >= 0; s--) if (pending[ch][s]) c = s + 1;
      w[8 + 3*ch +: 3] = 3'(c);
      w[ch] = (c != 0);
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (pending[i, j]) pending[i][j] = 0;
      expIrq = 0;
    end else begin
      expIrq = (modelWord() & 32'hFF) != 0;
      for (int ch = 0; ch < 8; ch++) begin
        bit req [7];
        req[0] = lineStatReq[ch]; req[1] = rxDataReq[ch]; req[2] = rxTimeoutReq[ch];
        req[3] = txEmptyReq[ch];  req[4] = modemReq[ch];
        req[5] = (ch == 0) && (timerReq || gpioReq);
        req[6] = (ch == 0) && wakeEvent && (chanAsleep == 8'hFF);
        for (int s = 0; s < 7; s++)
          pending[ch][s] = (pending[ch][s] && !srcAck[ch]) || req[s];
      end
    end
    expWord = modelWord();
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      for (int ch = 0; ch < 8; ch++)
        check("R4 code vs model", 32'(intStatus[8 + 3*ch +: 3]), 32'(expWord[8 + 3*ch +: 3]));
      check("R2 summary vs model", 32'(intStatus[7:0]), 32'(expWord[7:0]));
      check("R10 irq vs model", 32'(hostIrq), 32'(expIrq));
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clearIns();
    lineStatReq = '0; rxDataReq = '0; rxTimeoutReq = '0; txEmptyReq = '0;
    modemReq = '0; timerReq = 0; gpioReq = 0; wakeEvent = 0; srcAck = '0;
  endtask

  function automatic logic [31:0] fld(int ch);
    return 32'(intStatus[8 + 3*ch +: 3]);
  endfunction

  task automatic summarize();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=hung expected=finished");
    summarize();
  end

  initial begin
    // R1 reset state
    cyc(); cyc();
    check("R1 status in reset", intStatus, 32'h0);
    check("R1 irq in reset", 32'(hostIrq), 32'h0);
    rstN = 1; cyc();
    check("R1 status after reset", intStatus, 32'h0);

    // R3 R4 line status on channel 3, R10 irq one cycle later
    lineStatReq[3] = 1; cyc(); clearIns();
    check("R3 ch3 field", intStatus, 32'h0002_0008);
    check("R10 irq not yet", 32'(hostIrq), 32'h0);
    cyc();
    check("R10 irq raised", 32'(hostIrq), 32'h1);
    check("R5 held after pulse", fld(3), 32'h1);
    srcAck[3] = 1; cyc(); clearIns();
    check("R5 ack clears ch3", fld(3), 32'h0);
    cyc();
    check("R10 irq dropped", 32'(hostIrq), 32'h0);

    // R4 R6 priority, ack with tx still held on channel 5
    rxDataReq[5] = 1; txEmptyReq[5] = 1; modemReq[5] = 1; cyc();
    rxDataReq[5] = 0; modemReq[5] = 0;
    check("R4 rx over tx and modem", fld(5), 32'h2);
    srcAck[5] = 1; cyc(); srcAck[5] = 0; txEmptyReq[5] = 0;
    check("R6 tx replaces after ack", fld(5), 32'h4);
    check("R3 ch5 word", intStatus, 32'h0200_0020);
    srcAck[5] = 1; cyc(); clearIns();
    check("R5 ch5 cleared", fld(5), 32'h0);

    // R3 R4 receive timeout on channel 7, top bits
    rxTimeoutReq[7] = 1; modemReq[7] = 1; cyc(); clearIns();
    check("R3 ch7 at top bits", intStatus, 32'h6000_0080);
    srcAck[7] = 1; cyc(); clearIns();

    // R6 request in the same cycle as its acknowledge
    lineStatReq[2] = 1; srcAck[2] = 1; cyc(); clearIns();
    check("R6 set wins over ack", fld(2), 32'h1);
    srcAck[2] = 1; cyc(); clearIns();
    check("R5 plain ack clears ch2", fld(2), 32'h0);

    // R7 device sources only in channel 0
    timerReq = 1; cyc(); clearIns();
    check("R7 timer in ch0", fld(0), 32'h6);
    check("R7 other channels clear", intStatus & 32'hFFFF_F8FE, 32'h0);
    srcAck[0] = 1; cyc(); clearIns();
    gpioReq = 1; cyc(); clearIns();
    check("R7 gpio in ch0", intStatus, 32'h0000_0601);
    srcAck[0] = 1; cyc(); clearIns();

    // R9 wake with one channel awake is ignored
    chanAsleep = 8'h7F; wakeEvent = 1; cyc(); clearIns();
    check("R9 partial sleep wake ignored", intStatus, 32'h0);
    cyc();
    check("R9 still nothing", intStatus, 32'h0);

    // R8 wake with all asleep is latched until channel 0 ack
    chanAsleep = 8'hFF; wakeEvent = 1; cyc(); clearIns();
    check("R8 wake code", fld(0), 32'h7);
    cyc(); cyc();
    check("R8 wake latched", intStatus, 32'h0000_0701);
    timerReq = 1; cyc(); clearIns();
    check("R4 timer over wake", fld(0), 32'h6);
    srcAck[0] = 1; cyc(); clearIns();
    check("R8 ack clears wake", fld(0), 32'h0);
    wakeEvent = 1; srcAck[0] = 1; cyc(); clearIns();
    check("R8 wake set wins over ack", fld(0), 32'h7);
    srcAck[0] = 1; cyc(); clearIns();
    chanAsleep = 8'h00;

    // mixed load: several channels at once
    for (int k = 0; k < 40; k++) begin
      lineStatReq = 8'(k * 37); rxDataReq = 8'(k * 11); txEmptyReq = 8'(k * 5 + 3);
      modemReq = 8'(k * 73); rxTimeoutReq = 8'(k * 19);
      srcAck = 8'(k * 29); timerReq = k[2]; chanAsleep = (k % 7 == 0) ? 8'hFF : 8'hFE;
      wakeEvent = k[0];
      cyc();
    end
    clearIns(); chanAsleep = '0;
    srcAck = 8'hFF; cyc(); clearIns(); cyc();
    check("R5 all cleared", intStatus, 32'h0);
    check("R10 irq low when idle", 32'(hostIrq), 32'h0);

    cyc();
    summarize();
  end
endmodule